// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire (SMBus-style) slave that lets a host read and write a bank of 8-bit configuration registers. It answers at 7-bit address 0x69 and accepts four transaction kinds: byte write, byte read, block write and block read. The command byte that follows the write address selects the kind. With its top bit set, the access is a single byte at the 7-bit offset in the low bits. With that bit clear, the access is a block that starts at offset 0.

Writes are gated in two ways. A write-enable bit opens the bank, and its new value is only picked up when the next block write begins. A one-time lock freezes the whole bank until reset; writes made after locking are still acknowledged but change nothing. A few registers are read-only: one reports the frequency-select and clock-select straps sampled just after reset, one reports the two 33/66 mode straps, and two hold fixed identification codes.

The SCL and SDA lines are sampled with the system clock, so the block runs in a single clock domain. Every register is also driven onto a wide parallel output for the logic that consumes the configuration.

Top module: `smb_cfg_slave`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read), i.e. 7-bit address 0x69, is acknowledged. So is every command, count and data byte that follows it. Any other address is not acknowledged, and the slave then ignores the bus until the next start condition.
- R2: A command byte with bit 7 = 1 selects a byte access at the offset held in bits 6:0. A following data byte writes that register. A repeated start with address 0xD3 returns that register's value.
- R3: Command 0x00 selects a block write. The next byte is a count and is acknowledged. Each data byte after it goes to offsets 0, 1, 2 and so on, in order. A stop after any complete byte leaves the higher registers unchanged.
- R4: A block read (command 0x00, repeated start, address 0xD3) first returns a count equal to the number of registers (12 by default). It then returns registers from offset 0 upward until the master does not acknowledge a byte.
- R5: Bit 0 of register 0 is the write enable, and the effective enable is 0 after reset. While the effective enable is 0, only bit 0 of register 0 can change. A new value of bit 0 becomes the effective enable when the count byte of the next block write arrives.
- R6: While writes are enabled, writing register 0 with bit 7 = 1 while its bit 0 is already 1 locks the bank. From then until reset, every write is acknowledged but changes no register. Register 0 then reads back with bit 7 set.
- R7: The following registers are read-only and ignore writes: register 4 = {clock-select strap, 000, frequency straps[3:0]}, register 7 = vendor code (default 0x4A), register 8 = device code (default 0x2C), register 11 = {0, mode straps[1:0], 00000}. The strap values are captured on the first clock after reset.
- R8: Offsets at or above the register count read as 0x00, and writes to them change nothing.
- R9: Bytes go out most significant bit first. The slave changes its SDA drive only while SCL is low.
- R10: The configuration output carries register i on bits [8i+7:8i].
- R11: After reset, the writable registers hold: register 0 = 0x20, register 1 = 0xFF, register 2 = 0xFE, register 3 = 0x07, all others 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired line, including this slave's own drive) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_fs_i | input | 4 | Frequency-select straps, captured after reset |
| strap_sel_i | input | 1 | Clock-select strap, captured after reset |
| strap_mode_i | input | 2 | 33/66 mode straps, captured after reset |
| cfg_o | output | NREG*8 | All registers side by side, register i at [8i+7:8i] |

## Verification
The assertions rely on the master changing SDA only while SCL is low, except when it makes a start or a stop. They also rely on the master never making a start or a stop while the slave holds SDA low. Each SCL phase must last longer than the synchronizer latency, which is about four clocks. The bench's bus tasks hold every SCL phase for at least ten clocks and change SDA only a quarter period after SCL falls. It issues starts and stops only after the slave has released the line, so the wired bus never leaves those bounds.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam logic [6:0] SLAVE_ADDR7 = 7'h69;
  localparam int         MIN_REGS    = 12;

  typedef enum logic [2:0] {
    RK_RW,
    RK_STRAP,
    RK_VID,
    RK_DID,
    RK_MODE
  } reg_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_WDATA,
    PH_SKIP,
    PH_READ
  } phase_e;

  typedef enum logic [2:0] {
    BE_IDLE,
    BE_RX,
    BE_WAITA,
    BE_ACK,
    BE_TX,
    BE_ACKIN
  } bit_state_e;

  // which storage kind sits at a given offset
  function automatic reg_kind_e kind_of(input int idx);
    case (idx)
      4:       return RK_STRAP;
      7:       return RK_VID;
      8:       return RK_DID;
      11:      return RK_MODE;
      default: return RK_RW;
    endcase
  endfunction

  function automatic logic [7:0] reset_value(input int idx);
    case (idx)
      0:       return 8'h20;
      1:       return 8'hFF;
      2:       return 8'hFE;
      3:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic addr_hit(input logic [7:0] b);
    return b[7:1] == SLAVE_ADDR7;
  endfunction

  function automatic logic [7:0] strap_word(input logic sel, input logic [3:0] fs);
    return {sel, 3'b000, fs};
  endfunction

  function automatic logic [7:0] mode_word(input logic [1:0] m);
    return {1'b0, m, 5'b00000};
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prv;

  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], raw[l]};
    end
    assign lvl[l] = sh[STAGES-1];
    assign prv[l] = sh[STAGES];
  end

  assign scl_s     = lvl[1];
  assign sda_s     = lvl[0];
  assign scl_rise  = lvl[1] & ~prv[1];
  assign scl_fall  = ~lvl[1] & prv[1];
  assign start_evt = lvl[1] & prv[1] & prv[0] & ~lvl[0];
  assign stop_evt  = lvl[1] & prv[1] & ~prv[0] & lvl[0];

endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
  import smb_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       sda_s,
  input  logic       ack_want,
  input  logic       tx_mode,
  input  logic [7:0] tx_byte,
  output logic       rx_done,
  output logic [7:0] rx_byte,
  output logic       tx_done,
  output logic       tx_acked,
  output logic       sda_oe
);

  bit_state_e st;
  logic [3:0] bitcnt;
  logic [7:0] sh;

  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= BE_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      sda_oe   <= 1'b0;
      rx_done  <= 1'b0;
      tx_done  <= 1'b0;
      tx_acked <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      tx_done <= 1'b0;
      if (stop_evt) begin
        st     <= BE_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        st     <= BE_RX;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          BE_RX: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              if (bitcnt == 4'd7) begin
                bitcnt  <= '0;
                st      <= BE_WAITA;
                rx_done <= 1'b1;
              end else begin
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          BE_WAITA: begin
            if (scl_fall) begin
              if (ack_want) begin
                sda_oe <= 1'b1;
                st     <= BE_ACK;
              end else begin
                st <= BE_IDLE;
              end
            end
          end
          BE_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (tx_mode) begin
                sh     <= tx_byte;
                sda_oe <= ~tx_byte[7];
                st     <= BE_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= BE_RX;
              end
            end
          end
          BE_TX: begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= BE_ACKIN;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          BE_ACKIN: begin
            if (scl_rise) begin
              tx_done  <= 1'b1;
              tx_acked <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (tx_acked) begin
                sh     <= tx_byte;
                sda_oe <= ~tx_byte[7];
                st     <= BE_TX;
              end else begin
                st <= BE_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int         NREG      = 12,
  parameter logic [7:0] VENDOR_ID = 8'h4A,
  parameter logic [7:0] DEVICE_ID = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [6:0]        waddr,
  input  logic [7:0]        wdata,
  input  logic              snap,
  input  logic [6:0]        raddr,
  output logic [7:0]        rdata,
  input  logic [3:0]        strap_fs,
  input  logic              strap_sel,
  input  logic [1:0]        strap_mode,
  output logic [NREG*8-1:0] flat
);

  localparam logic [7:0] NREG8 = 8'(NREG);

  logic       cap;
  logic [3:0] fs_q;
  logic       sel_q;
  logic [1:0] mode_q;
  logic       locked;
  logic       wr_open;
  logic       lock_set;

  // strap capture on the first clock after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap    <= 1'b0;
      fs_q   <= '0;
      sel_q  <= 1'b0;
      mode_q <= '0;
    end else if (!cap) begin
      cap    <= 1'b1;
      fs_q   <= strap_fs;
      sel_q  <= strap_sel;
      mode_q <= strap_mode;
    end
  end

  assign lock_set = we && (waddr == 7'd0) && !locked && wr_open && flat[0] && wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      wr_open <= 1'b0;
    end else begin
      if (lock_set) locked <= 1'b1;
      if (snap && !locked) wr_open <= flat[0];
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam reg_kind_e K = kind_of(i);
    if (K == RK_RW) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= reset_value(i);
        end else if (we && (waddr == 7'(i)) && !locked) begin
          if (wr_open)     q    <= wdata;
          else if (i == 0) q[0] <= wdata[0];
        end
      end
      assign flat[i*8 +: 8] = q;
    end else if (K == RK_STRAP) begin : g_strap
      assign flat[i*8 +: 8] = strap_word(sel_q, fs_q);
    end else if (K == RK_VID) begin : g_vid
      assign flat[i*8 +: 8] = VENDOR_ID;
    end else if (K == RK_DID) begin : g_did
      assign flat[i*8 +: 8] = DEVICE_ID;
    end else begin : g_mode
      assign flat[i*8 +: 8] = mode_word(mode_q);
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (raddr == 7'(i)) rdata = flat[i*8 +: 8];
    end
  end

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cap) |=> $stable(flat));

  p_closed_bit0_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_open && cap) |=> $stable(flat[NREG*8-1:1]));

  p_oob_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ({1'b0, waddr} >= NREG8) && cap) |=> $stable(flat));

  p_strap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> ($stable(fs_q) && $stable(sel_q) && $stable(mode_q)));

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         NREG        = 12,
  parameter logic [7:0] VENDOR_ID   = 8'h4A,
  parameter logic [7:0] DEVICE_ID   = 8'h2C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [3:0]        strap_fs_i,
  input  logic              strap_sel_i,
  input  logic [1:0]        strap_mode_i,
  output logic [NREG*8-1:0] cfg_o
);

  localparam logic [7:0] COUNT_BYTE = 8'(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic rx_done, tx_done, tx_acked;
  logic [7:0] rx_byte, tx_byte, rd_data;

  phase_e     phase;
  logic       cmd_block;
  logic [6:0] ptr;
  logic       cnt_pending;
  logic       ack_want;
  logic       tx_mode;

  // named internal events
  logic we_evt;
  logic snap_evt;
  logic foreign_addr;

  assign we_evt       = rx_done && (phase == PH_WDATA);
  assign snap_evt     = rx_done && (phase == PH_COUNT);
  assign foreign_addr = rx_done && (phase == PH_ADDR) && !addr_hit(rx_byte);
  assign tx_byte      = cnt_pending ? COUNT_BYTE : rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  smb_byte_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_s     (sda_s),
    .ack_want  (ack_want),
    .tx_mode   (tx_mode),
    .tx_byte   (tx_byte),
    .rx_done   (rx_done),
    .rx_byte   (rx_byte),
    .tx_done   (tx_done),
    .tx_acked  (tx_acked),
    .sda_oe    (sda_oe_o)
  );

  smb_cfg_regs #(
    .NREG      (NREG),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (we_evt),
    .waddr      (ptr),
    .wdata      (rx_byte),
    .snap       (snap_evt),
    .raddr      (ptr),
    .rdata      (rd_data),
    .strap_fs   (strap_fs_i),
    .strap_sel  (strap_sel_i),
    .strap_mode (strap_mode_i),
    .flat       (cfg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      cmd_block   <= 1'b1;
      ptr         <= '0;
      cnt_pending <= 1'b0;
      ack_want    <= 1'b0;
      tx_mode     <= 1'b0;
    end else if (stop_evt) begin
      phase   <= PH_IDLE;
      tx_mode <= 1'b0;
    end else if (start_evt) begin
      phase    <= PH_ADDR;
      tx_mode  <= 1'b0;
      ack_want <= 1'b0;
    end else if (rx_done) begin
      case (phase)
        PH_ADDR: begin
          if (addr_hit(rx_byte)) begin
            ack_want <= 1'b1;
            if (rx_byte[0]) begin
              tx_mode     <= 1'b1;
              phase       <= PH_READ;
              cnt_pending <= cmd_block;
              if (cmd_block) ptr <= '0;
            end else begin
              phase <= PH_CMD;
            end
          end else begin
            ack_want <= 1'b0;
            phase    <= PH_IDLE;
          end
        end
        PH_CMD: begin
          ack_want  <= 1'b1;
          cmd_block <= ~rx_byte[7];
          ptr       <= rx_byte[7] ? rx_byte[6:0] : 7'd0;
          phase     <= rx_byte[7] ? PH_WDATA : PH_COUNT;
        end
        PH_COUNT: begin
          ack_want <= 1'b1;
          phase    <= PH_WDATA;
        end
        PH_WDATA: begin
          ack_want <= 1'b1;
          if (cmd_block) ptr   <= ptr + 7'd1;
          else           phase <= PH_SKIP;
        end
        PH_SKIP:  ack_want <= 1'b1;
        default:  ack_want <= 1'b0;
      endcase
    end else if (tx_done && tx_acked) begin
      if (cnt_pending) cnt_pending <= 1'b0;
      else             ptr         <= ptr + 7'd1;
    end
  end

  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  p_foreign_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (foreign_addr && !start_evt && !stop_evt) |=> (phase == PH_IDLE && !ack_want));

  p_block_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_evt && cmd_block && !start_evt && !stop_evt) |=> (ptr == $past(ptr) + 7'd1));

endmodule

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;

  localparam int NREG = 12;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg;
  wire  sda_line = sda_m & ~sda_oe;

  logic [3:0] fs_strap   = 4'b1010;
  logic       sel_strap  = 1'b1;
  logic [1:0] mode_strap = 2'b10;

  smb_cfg_slave u_smb_cfg_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .strap_fs_i   (fs_strap),
    .strap_sel_i  (sel_strap),
    .strap_mode_i (mode_strap),
    .cfg_o        (cfg)
  );

  int checks = 0;
  int bad    = 0;
  int viol   = 0;
  bit done   = 0;
  logic oe_prev = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];
  logic [7:0] wbuf[8];

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input int idx, input logic [7:0] exp);
    chk(tag, int'(cfg[idx*8 +: 8]), int'(exp));
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(g), int'(e));
      end
    end
  end

  // slave may only move SDA while SCL is low
  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe !== oe_prev)) viol++;
    oe_prev = sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic w;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; w();
    sda_m = 1'b0; w();
    scl_m = 1'b0; w();
  endtask

  task automatic bus_rstart;
    sda_m = 1'b1; w();
    scl_m = 1'b1; w();
    sda_m = 1'b0; w();
    scl_m = 1'b0; w();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w();
    scl_m = 1'b1; w();
    sda_m = 1'b1; w(); w();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; w();
    scl_m = 1'b1; w(); w();
    scl_m = 1'b0; w();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; w();
    scl_m = 1'b1; w();
    b = sda_line; w();
    scl_m = 1'b0; w();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(s);
      b[i] = s;
    end
    send_bit(!give_ack);
  endtask

  task automatic wr1(input logic [6:0] off, input logic [7:0] v, input string tag);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte({1'b1, off}, a1);
    send_byte(v, a2);
    bus_stop();
    chk({tag, " ack"}, int'({a0, a1, a2}), 7);
  endtask

  task automatic rd1(input logic [6:0] off, input logic [7:0] exp, input string tag);
    logic a0, a1, a2;
    logic [7:0] b;
    expect_rd(tag, exp);
    bus_start();
    send_byte(8'hD2, a0);
    send_byte({1'b1, off}, a1);
    bus_rstart();
    send_byte(8'hD3, a2);
    recv_byte(1'b0, b);
    bus_stop();
    got_q.push_back(b);
    chk({tag, " ack"}, int'({a0, a1, a2}), 7);
  endtask

  task automatic blk_wr(input int n, input string tag);
    logic a;
    int acks;
    acks = 0;
    bus_start();
    send_byte(8'hD2, a); acks += int'(a);
    send_byte(8'h00, a); acks += int'(a);
    send_byte(8'(n), a); acks += int'(a);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      acks += int'(a);
    end
    bus_stop();
    chk({tag, " ack count"}, acks, n + 3);
  endtask

  task automatic blk_rd(input int n, input string tag);
    logic a0, a1, a2;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(8'h00, a1);
    bus_rstart();
    send_byte(8'hD3, a2);
    recv_byte(1'b1, b);
    got_q.push_back(b);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      got_q.push_back(b);
    end
    bus_stop();
    chk({tag, " ack"}, int'({a0, a1, a2}), 7);
  endtask

  initial begin
    logic a0, a1;
    logic [NREG*8-1:0] snapv;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state: R11, R7, R10
    chk_reg("R11 reg0 reset", 0, 8'h20);
    chk_reg("R11 reg1 reset", 1, 8'hFF);
    chk_reg("R11 reg2 reset", 2, 8'hFE);
    chk_reg("R11 reg3 reset", 3, 8'h07);
    chk_reg("R11 reg5 reset", 5, 8'h00);
    chk_reg("R7 strap reg4", 4, 8'h8A);
    chk_reg("R7 vendor reg7", 7, 8'h4A);
    chk_reg("R10 device reg8", 8, 8'h2C);
    chk_reg("R7 mode reg11", 11, 8'h40);
    chk("R9 sda idle", int'(sda_oe), 0);

    // R1: foreign address is not acknowledged, following byte ignored
    bus_start();
    send_byte(8'hA0, a0);
    send_byte(8'h85, a1);
    bus_stop();
    chk("R1 foreign addr nack", int'(a0), 0);
    chk("R1 ignored after nack", int'(a1), 0);

    // R5: closed bank ignores writes to reg1
    wr1(7'd1, 8'h12, "R1 byte write");
    repeat (4) @(negedge clk);
    chk_reg("R5 closed reg1", 1, 8'hFF);

    // R5: bit0 of reg0 still writable
    wr1(7'd0, 8'h01, "R5 enable write");
    repeat (4) @(negedge clk);
    chk_reg("R5 reg0 bit0", 0, 8'h21);

    // R5: enable not yet effective before a block write
    wr1(7'd1, 8'h12, "R5 pending");
    repeat (4) @(negedge clk);
    chk_reg("R5 still closed", 1, 8'hFF);

    // R3: block write of three bytes, stop early
    wbuf[0] = 8'h01; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
    blk_wr(3, "R3 block write");
    repeat (4) @(negedge clk);
    chk_reg("R3 reg0", 0, 8'h01);
    chk_reg("R3 reg1", 1, 8'h34);
    chk_reg("R3 reg2", 2, 8'h56);
    chk_reg("R3 reg3 untouched", 3, 8'h07);

    // R2: byte write and byte read
    wr1(7'd3, 8'hA5, "R2 byte write");
    repeat (4) @(negedge clk);
    chk_reg("R2 reg3", 3, 8'hA5);
    rd1(7'd1, 8'h34, "R2 byte read reg1");
    rd1(7'd7, 8'h4A, "R7 read vendor");
    rd1(7'd8, 8'h2C, "R7 read device");
    rd1(7'd4, 8'h8A, "R7 read strap");
    rd1(7'd11, 8'h40, "R7 read mode");

    // R7: read-only ignores writes
    wr1(7'd7, 8'hFF, "R7 ro write");
    repeat (4) @(negedge clk);
    chk_reg("R7 vendor kept", 7, 8'h4A);
    rd1(7'd7, 8'h4A, "R7 vendor readback");

    // R8: out-of-range offsets
    snapv = cfg;
    wr1(7'd13, 8'h77, "R8 oob write");
    repeat (4) @(negedge clk);
    checks++;
    if (cfg !== snapv) begin
      bad++;
      $display("FAIL R8 oob write: got 0x%0h expected 0x%0h", cfg, snapv);
    end
    rd1(7'd13, 8'h00, "R8 oob read 13");
    rd1(7'h50, 8'h00, "R8 oob read 0x50");

    // R4: block read, count then registers from 0
    expect_rd("R4 count", 8'h0C);
    expect_rd("R4 data0", 8'h01);
    expect_rd("R4 data1", 8'h34);
    expect_rd("R4 data2", 8'h56);
    expect_rd("R4 data3", 8'hA5);
    expect_rd("R4 data4", 8'h8A);
    blk_rd(5, "R4 block read");

    // R6: lock
    wr1(7'd0, 8'h81, "R6 lock write");
    repeat (4) @(negedge clk);
    chk_reg("R6 reg0 locked", 0, 8'h81);
    wr1(7'd1, 8'h99, "R6 write after lock");
    repeat (4) @(negedge clk);
    chk_reg("R6 reg1 frozen", 1, 8'h34);
    wbuf[0] = 8'h00; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
    blk_wr(3, "R6 block after lock");
    repeat (4) @(negedge clk);
    chk_reg("R6 reg2 frozen", 2, 8'h56);
    wr1(7'd0, 8'h00, "R6 unlock attempt");
    rd1(7'd0, 8'h81, "R6 reg0 readback");

    repeat (20) @(negedge clk);
    while (got_q.size() > 0) @(negedge clk);
    chk("R9 sda moved while scl high", viol, 0);
    chk("scoreboard leftovers", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule